// File: doc/BRIEF.md
# CAN Transmitter Enable Guard with Dominant Timeout and Thermal Latch

This block decides, every clock cycle, whether the CAN bus driver may pull the bus dominant. It watches the transmit-data pin (low means a dominant request, high means recessive), an over-temperature flag from the thermal sensor, and the normal-mode indication from the mode controller. It produces one driver-dominant command and two status bits that say which protection currently holds the driver off.

Two protections are built in. A dominant timer stops a transmit pin that is stuck low from blocking the network. A thermal latch switches the driver off when the die runs hot. Both protections are latched. Neither is released when the timer stops or when the temperature drops. Each is released only by a rising edge on the transmit pin. The timeout length is a parameter in clock cycles. A typical timeout is 650 µs, allowed between 300 and 1000 µs, which sets the slowest usable bit rate at 40 kbit/s. The default of 6500 cycles suits a 10 MHz clock.

The pin is synchronised through two flops. A three-state machine then tracks it. ST_RECESSIVE is idle, with the bus released. ST_DOMINANT means a dominant request is being honoured and timed. ST_BLOCKED means a protection holds the driver off. The transitions are:
- START: ST_RECESSIVE to ST_DOMINANT, when the pin is seen low.
- RELEASE: ST_DOMINANT to ST_RECESSIVE, when the pin is seen high.
- EXPIRE: ST_DOMINANT to ST_BLOCKED, when the timer reaches its limit.
- OVERHEAT: from ST_RECESSIVE or ST_DOMINANT to ST_BLOCKED, when the flag is high.
- UNBLOCK: ST_BLOCKED to ST_RECESSIVE, on a synchronised rising edge of the pin with the flag low.

Top module: `txen_guard`

## Requirements
- R1: After reset, drive_dom, stat_timeout and stat_thermal are all 0.
- R2: In normal mode, a low pulse on txd_pin lasting L cycles, where L is at most TMO_CYC, gives drive_dom high for exactly L consecutive cycles. The first of those cycles follows the third clock edge after the pin falls.
- R3: If txd_pin stays low for more than TMO_CYC cycles, drive_dom is high for exactly TMO_CYC cycles and then returns low, and stat_timeout goes to 1. A low pulse of exactly TMO_CYC cycles never sets stat_timeout.
- R4: While stat_timeout is 1, drive_dom stays 0 however long txd_pin remains low. The timer saturates and never wraps. stat_timeout clears only on a rising edge of txd_pin, within three cycles of the pin going high.
- R5: With normal_mode at 0, drive_dom is 0 for any txd_pin activity. The timeout is still tracked and reported on stat_timeout.
- R6: When hot_flag is 1 at a clock edge, drive_dom is 0 from the next cycle on, and stat_thermal is 1. This holds whether the pin is high or low at that moment.
- R7: stat_thermal and the blocked driver persist after hot_flag returns to 0. They clear only on a txd_pin rising edge seen while hot_flag is 0. A later low pulse before that release produces no dominant cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_pin | input | 1 | Transmit data from the controller. Low requests dominant, high or floating means recessive |
| hot_flag | input | 1 | Over-temperature flag from the thermal sensor, synchronous to clk |
| normal_mode | input | 1 | 1 in normal mode, 0 in standby |
| drive_dom | output | 1 | Driver command. 1 drives the bus dominant |
| stat_timeout | output | 1 | 1 while the dominant-timeout latch holds the driver off |
| stat_thermal | output | 1 | 1 while the thermal latch holds the driver off |

## Verification
A state machine stuck in ST_BLOCKED shows up on the next low pulse as zero dominant cycles. A state machine that leaves ST_BLOCKED early shows up as dominant cycles while a status bit is still 1. An off-by-one timer limit changes the dominant run of a long pulse by one cycle, and it makes a pulse of exactly TMO_CYC cycles report a timeout. A timer that wraps brings drive_dom back during a long low pulse. All of these errors show within a few cycles of the pin edge that exposes them. The sweep therefore compares, for every pulse length, the number of dominant cycles and whether a timeout was seen against arithmetic expectations.

// File: rtl/txg_pkg.sv
package txg_pkg;
    typedef enum logic [1:0] {
        ST_RECESSIVE = 2'd0,
        ST_DOMINANT  = 2'd1,
        ST_BLOCKED   = 2'd2
    } txg_state_e;
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
    parameter int TMO_CYC = 6500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/txen_guard.sv
module txen_guard
    import txg_pkg::*;
#(
    parameter int TMO_CYC     = 6500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_pin,
    input  logic hot_flag,
    input  logic normal_mode,
    output logic drive_dom,
    output logic stat_timeout,
    output logic stat_thermal
);
    logic       txd_s, txd_d;
    logic       rise;
    logic       expired;
    txg_state_e state_q, state_n;
    logic       tmo_q, thr_q;

    txg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (txd_pin),
        .q_out (txd_s)
    );

    txg_dom_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (~txd_s),
        .expired (expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd_d <= 1'b1;
        else        txd_d <= txd_s;
    end

    assign rise = txd_s & ~txd_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RECESSIVE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RECESSIVE: begin
                if (hot_flag)    state_n = ST_BLOCKED;
                else if (!txd_s) state_n = ST_DOMINANT;
            end
            ST_DOMINANT: begin
                if (hot_flag)     state_n = ST_BLOCKED;
                else if (txd_s)   state_n = ST_RECESSIVE;
                else if (expired) state_n = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (rise && !hot_flag) state_n = ST_RECESSIVE;
            end
            default: state_n = ST_RECESSIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q <= 1'b0;
            thr_q <= 1'b0;
        end else begin
            if (state_q == ST_DOMINANT && !txd_s && expired) tmo_q <= 1'b1;
            else if (rise)                                  tmo_q <= 1'b0;
            if (hot_flag)  thr_q <= 1'b1;
            else if (rise) thr_q <= 1'b0;
        end
    end

    always_comb begin
        drive_dom    = (state_q == ST_DOMINANT) && normal_mode;
        stat_timeout = tmo_q;
        stat_thermal = thr_q;
    end
endmodule

// File: rtl/txen_guard_chk.sv
module txen_guard_chk #(
    parameter int TMO_CYC = 6500
) (
    input logic clk,
    input logic rst_n,
    input logic txd_pin,
    input logic hot_flag,
    input logic normal_mode,
    input logic drive_dom,
    input logic stat_timeout,
    input logic stat_thermal
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= 0;
        else if (drive_dom) run_q <= run_q + 1;
        else                run_q <= 0;
    end

    assert_dom_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_dom |-> !$past(txd_pin, 3));

    assert_max_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_dom |-> (run_q < TMO_CYC));

    assert_latched_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_timeout || stat_thermal) |-> !drive_dom);

    assert_timeout_clear_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_timeout) |-> $past(txd_pin, 3));

    assert_standby_recessive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_mode |-> !drive_dom);

    assert_hot_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag |=> (!drive_dom && stat_thermal));

    assert_thermal_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_thermal) |-> ($past(txd_pin, 3) && !$past(hot_flag)));
endmodule

bind txen_guard txen_guard_chk #(.TMO_CYC(TMO_CYC)) u_chk (.*);

// File: tb/tb_txen_guard.sv
`timescale 1ns/1ps
module tb_txen_guard;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_pin = 1'b1;
    logic hot_flag = 1'b0;
    logic normal_mode = 1'b1;
    logic drive_dom, stat_timeout, stat_thermal;

    int checks = 0;
    int fails = 0;
    int dom_cnt, tmo_seen, thr_seen, thr_at_low_end;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txen_guard #(.TMO_CYC(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .txd_pin(txd_pin), .hot_flag(hot_flag),
        .normal_mode(normal_mode), .drive_dom(drive_dom),
        .stat_timeout(stat_timeout), .stat_thermal(stat_thermal)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // low for L cycles (pin low before edges 1..L), hot before edges hf..ht, then 6 recessive cycles
    task automatic pulse(input int L, input int hf, input int ht);
        dom_cnt = 0; tmo_seen = 0; thr_seen = 0; thr_at_low_end = 0;
        for (int i = 1; i <= L + 6; i++) begin
            txd_pin  = (i <= L) ? 1'b0 : 1'b1;
            hot_flag = (i >= hf && i <= ht) ? 1'b1 : 1'b0;
            @(posedge clk); #1;
            if (drive_dom)    dom_cnt++;
            if (stat_timeout) tmo_seen = 1;
            if (stat_thermal) thr_seen = 1;
            if (i == L)       thr_at_low_end = int'(stat_thermal);
        end
        hot_flag = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 drive_dom", int'(drive_dom), 0);
        check("R1 stat_timeout", int'(stat_timeout), 0);
        check("R1 stat_thermal", int'(stat_thermal), 0);

        // R2/R3/R4 sweep over pulse lengths, including the saturated range
        for (int L = 1; L <= 3 * LIM; L++) begin
            pulse(L, 0, -1);
            check($sformatf("R2/R3 dominant cycles L=%0d", L), dom_cnt, (L < LIM) ? L : LIM);
            check($sformatf("R3 timeout seen L=%0d", L), tmo_seen, (L > LIM) ? 1 : 0);
            check($sformatf("R4 timeout cleared L=%0d", L), int'(stat_timeout), 0);
        end

        // R5 standby: no dominant, timeout still tracked
        normal_mode = 1'b0;
        pulse(5, 0, -1);
        check("R5 standby short dominant", dom_cnt, 0);
        pulse(LIM + 4, 0, -1);
        check("R5 standby long dominant", dom_cnt, 0);
        check("R5 standby timeout seen", tmo_seen, 1);
        normal_mode = 1'b1;
        pulse(4, 0, -1);
        check("R5 normal resumes", dom_cnt, 4);

        // R6/R7 overheat in the middle of a dominant pulse
        pulse(20, 5, 6);
        check("R6 dominant cut by hot", dom_cnt, 2);
        check("R6 thermal seen", thr_seen, 1);
        check("R7 thermal held after hot drops", thr_at_low_end, 1);
        check("R7 thermal cleared by rise", int'(stat_thermal), 0);

        // R7 rise while still hot does not release
        pulse(6, 1, 12);
        check("R7 thermal kept across hot rise", int'(stat_thermal), 1);
        pulse(4, 0, -1);
        check("R7 blocked pulse dominant", dom_cnt, 0);
        check("R7 release after cool rise", int'(stat_thermal), 0);
        pulse(4, 0, -1);
        check("R7 normal after release", dom_cnt, 4);

        // R6 overheat while idle
        pulse(0, 1, 1);
        check("R6 idle hot latches", int'(stat_thermal), 1);
        check("R6 idle hot no drive", int'(drive_dom), 0);
        pulse(5, 0, -1);
        check("R7 idle latch blocks pulse", dom_cnt, 0);
        check("R7 idle latch cleared", int'(stat_thermal), 0);
        pulse(5, 0, -1);
        check("R2 pulse after release", dom_cnt, 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule